// File: doc/BRIEF.md
# Line-Echo Stream Formatter

The formatter sits on the local side of a byte channel and turns it into a simple interactive console. Every byte that arrives on its inbound stream goes straight back out on the outbound stream, unchanged and in order. On top of that plain echo it adds light line decoration. A prompt character opens every line. A carriage return is followed by a line feed and then a fresh prompt.

Both streams use valid/ready handshaking. The block holds at most one pending byte. It accepts a new inbound byte only after it has fully delivered everything that the previous byte caused, so it never drops or duplicates data when the downstream side stalls.

Overrun bytes need no special handling. A receiver that has lost data hands over an exclamation mark (0x21), and the formatter echoes that character like any other byte.

Top module: `line_echo_fmt`

## Requirements
- R1: After reset, the first outbound byte is the prompt 0x3E. inReady stays low until that prompt has been taken.
- R2: Each inbound byte accepted on an inValid/inReady handshake is emitted on outData unchanged. Bytes leave in the order they arrived.
- R3: After the carriage return 0x0D has been echoed, the next two outbound bytes are the line feed 0x0A and then the prompt 0x3E. No inbound byte is accepted before both have been taken.
- R4: The overrun marker 0x21 is echoed exactly like any other byte, with no extra output.
- R5: inReady and outValid are never high together. After an inbound handshake, inReady stays low until the echo has been taken.
- R6: While outValid is high and outReady is low, outValid stays high and outData keeps its value. No outbound byte is lost or repeated under backpressure.
- R7: A synchronous active-high reset given in the middle of a line discards pending output and restarts with the prompt 0x3E.
- R8: The echoed byte is the one present on inData in the handshake cycle. Later changes of inData do not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inData | input | 8 | Inbound byte |
| inValid | input | 1 | Inbound byte present |
| inReady | output | 1 | Block can take an inbound byte |
| outData | output | 8 | Outbound byte |
| outValid | output | 1 | Outbound byte present |
| outReady | input | 1 | Downstream takes the outbound byte |

## Verification
The bench stalls the output, so a design that let the byte change or be skipped on a stall would put a wrong or missing character into the compared stream. Carriage returns are sent back to back and mixed with other bytes. A design that accepted input before delivering the line feed and prompt would interleave those out of order. The bench also corrupts inData right after each handshake, which exposes any design that samples the byte late. A reset in the middle of a line checks that stale echoes vanish and that the prompt is emitted again.

// File: rtl/lef_pkg.sv
package lef_pkg;

  typedef enum logic [1:0] {
    ST_PROMPT   = 2'd0,
    ST_WAIT_IN  = 2'd1,
    ST_ECHO     = 2'd2,
    ST_LINEFEED = 2'd3
  } lefState_t;

  typedef struct packed {
    logic capture;
    logic selPrompt;
    logic selEcho;
    logic selLf;
  } lefStrobes_t;

endpackage

// File: rtl/lef_ctrl.sv
module lef_ctrl
  import lef_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        outReady,
  input  logic        heldIsCr,
  output logic        inReady,
  output logic        outValid,
  output lefStrobes_t strobes
);

  lefState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_PROMPT;
    else     stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_PROMPT:   if (outReady) stateD = ST_WAIT_IN;
      ST_WAIT_IN:  if (inValid)  stateD = ST_ECHO;
      ST_ECHO:     if (outReady) stateD = heldIsCr ? ST_LINEFEED : ST_WAIT_IN;
      ST_LINEFEED: if (outReady) stateD = ST_PROMPT;
      default:     stateD = ST_PROMPT;
    endcase
  end

  always_comb begin
    inReady           = (stateQ == ST_WAIT_IN);
    outValid          = (stateQ != ST_WAIT_IN);
    strobes.capture   = inReady && inValid;
    strobes.selPrompt = (stateQ == ST_PROMPT);
    strobes.selEcho   = (stateQ == ST_ECHO);
    strobes.selLf     = (stateQ == ST_LINEFEED);
  end

  // R5: one accepted byte closes the input until its echo is out
  p_single_accept_r5: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> (!inReady && outValid));

  // R6: a stalled output stays offered
  p_hold_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> outValid);

endmodule

// File: rtl/lef_datapath.sv
module lef_datapath
  import lef_pkg::*;
#(
  parameter int                 DATA_W      = 8,
  parameter logic [DATA_W-1:0]  PROMPT_CHAR = 8'h3E,
  parameter logic [DATA_W-1:0]  CR_CHAR     = 8'h0D,
  parameter logic [DATA_W-1:0]  LF_CHAR     = 8'h0A
) (
  input  logic              clk,
  input  logic              rst,
  input  lefStrobes_t       strobes,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData,
  output logic              heldIsCr
);

  logic [DATA_W-1:0] heldByte;

  always_ff @(posedge clk) begin
    if (rst)                  heldByte <= '0;
    else if (strobes.capture) heldByte <= inData;
  end

  assign heldIsCr = (heldByte == CR_CHAR);

  always_comb begin
    outData = heldByte;
    if (strobes.selPrompt) outData = PROMPT_CHAR;
    else if (strobes.selLf) outData = LF_CHAR;
  end

endmodule

// File: rtl/line_echo_fmt.sv
module line_echo_fmt
  import lef_pkg::*;
#(
  parameter int                 DATA_W      = 8,
  parameter logic [DATA_W-1:0]  PROMPT_CHAR = 8'h3E,
  parameter logic [DATA_W-1:0]  CR_CHAR     = 8'h0D,
  parameter logic [DATA_W-1:0]  LF_CHAR     = 8'h0A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady
);

  lefStrobes_t strobes;
  logic        heldIsCr;

  lef_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .heldIsCr (heldIsCr),
    .inReady  (inReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  lef_datapath #(
    .DATA_W      (DATA_W),
    .PROMPT_CHAR (PROMPT_CHAR),
    .CR_CHAR     (CR_CHAR),
    .LF_CHAR     (LF_CHAR)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .inData   (inData),
    .outData  (outData),
    .heldIsCr (heldIsCr)
  );

  // R1 / R7: first cycle out of reset offers the prompt
  p_reset_prompt_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (outValid && outData == PROMPT_CHAR && !inReady));

  // R2: the echo carries the byte taken on the handshake
  p_echo_value_r2: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> (outValid && outData == $past(inData)));

  // R3: echoed CR is followed by LF
  p_lf_after_cr_r3: assert property (@(posedge clk) disable iff (rst)
    (strobes.selEcho && outReady && outData == CR_CHAR) |=>
      (outValid && outData == LF_CHAR));

  // R3: the injected LF is followed by a prompt
  p_prompt_after_lf_r3: assert property (@(posedge clk) disable iff (rst)
    (strobes.selLf && outReady) |=> (outValid && outData == PROMPT_CHAR));

  // R6: stalled data is held
  p_stable_data_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> $stable(outData));

endmodule

// File: tb/line_echo_fmt_bench.sv
module line_echo_fmt_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] inData = 8'h00;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] outData;
  logic       outValid;
  logic       outReady = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int bpMode = 2;          // 0: always ready, 1: pseudo-random, 2: never
  logic [7:0] lfsr = 8'hA5;

  logic [7:0] expData[$];
  string      expTag[$];
  logic       prevStall = 1'b0;
  logic [7:0] prevData = 8'h00;

  always #2.5 clk = ~clk;

  line_echo_fmt u_line_echo_fmt (
    .clk      (clk),
    .rst      (rst),
    .inData   (inData),
    .inValid  (inValid),
    .inReady  (inReady),
    .outData  (outData),
    .outValid (outValid),
    .outReady (outReady)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // backpressure driver
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    outReady <= (bpMode == 0) ? 1'b1 : (bpMode == 1) ? lfsr[0] : 1'b0;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    #1;
    if (rst) begin
      prevStall = 1'b0;
    end else begin
      check(!(inReady && outValid), "R5 inReady with outValid", {7'd0, inReady}, 8'h00);
      if (prevStall)
        check(outValid && outData == prevData, "R6 stalled byte changed", outData, prevData);
      if (outValid && outReady) begin
        if (expData.size() == 0) begin
          check(1'b0, "R2 unexpected output", outData, 8'hxx);
        end else begin
          logic [7:0] e;
          string t;
          e = expData.pop_front();
          t = expTag.pop_front();
          check(outData == e, t, outData, e);
        end
      end
      prevStall = outValid && !outReady;
      prevData  = outData;
    end
  end

  task automatic push(input logic [7:0] b, input string tag);
    expData.push_back(b);
    expTag.push_back(tag);
  endtask

  task automatic sendByte(input logic [7:0] b, input string tag);
    @(negedge clk);
    inData  = b;
    inValid = 1'b1;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    push(b, tag);
    if (b == 8'h0D) begin
      push(8'h0A, "R3 line feed after CR");
      push(8'h3E, "R3 prompt after line feed");
    end
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    inData  = ~b;           // R8: corrupt data after the handshake
  endtask

  task automatic drain();
    while (expData.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    push(8'h3E, "R1 prompt after reset");
    // R1: prompt offered and input closed while stalled
    repeat (3) begin
      @(negedge clk);
      #1;
      check(outValid && outData == 8'h3E, "R1 prompt offered", outData, 8'h3E);
      check(!inReady, "R1 inReady low before prompt", {7'd0, inReady}, 8'h00);
    end
    bpMode = 0;
    sendByte(8'h68, "R2 echo h");
    sendByte(8'h69, "R2 echo i");
    sendByte(8'h0D, "R3 CR echoed");
    sendByte(8'h21, "R4 overrun marker echoed");
    sendByte(8'h00, "R2 echo 0x00");
    sendByte(8'hFF, "R8 echo 0xFF with later corruption");
    sendByte(8'h0D, "R3 back-to-back CR 1");
    sendByte(8'h0D, "R3 back-to-back CR 2");
    drain();
    bpMode = 1;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] b;
      b = (i % 7 == 3) ? 8'h0D : ((i % 11 == 5) ? 8'h21 : 8'(8'h41 + i));
      sendByte(b, "R6 echo under backpressure");
    end
    drain();
    // R7: reset mid-line
    bpMode = 2;
    sendByte(8'h7A, "R7 pre-reset byte");
    @(negedge clk);
    rst = 1'b1;
    expData.delete();
    expTag.delete();
    repeat (2) @(negedge clk);
    push(8'h3E, "R7 prompt after mid-line reset");
    rst = 1'b0;
    #1;
    check(outValid && outData == 8'h3E, "R7 prompt offered after reset", outData, 8'h3E);
    bpMode = 0;
    sendByte(8'h51, "R7 echo after reset");
    drain();
    check(expData.size() == 0, "R2 scoreboard empty", 8'(expData.size()), 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 50000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule